// File: doc/BRIEF.md
# Transceiver Diagnostic Limit Comparator

This block holds the threshold and live-reading page of an optical transceiver's diagnostic memory. It compares each monitored quantity against four stored limits and produces the alarm and warning flag bytes. There are five quantities: die temperature, supply voltage, laser bias, transmit power and receive power. The four limits for each quantity are a high alarm, a low alarm, a high warning and a low warning.

A management agent writes limits and fresh readings one byte at a time. It then pulses a sample strobe. On that strobe every flag is recomputed from the stored words and loaded in a single cycle. Between strobes the flags hold their value, so a reader can never see a mix of old and new results. Reads are combinational over the same byte address space. They return stored limit and reading bytes, the four flag bytes, and zero everywhere else.

Top module: `diag_threshold_monitor`

## Requirements
- R1: After reset, every stored limit byte, every reading byte and all four flag bytes read as 0x00.
- R2: Limit words for quantity q (0 temperature, 1 supply, 2 bias, 3 transmit power, 4 receive power) start at byte 8q. Within that group the word order is high alarm, low alarm, high warning, low warning, each word 2 bytes. The live reading of quantity q is at byte 96+2q. All of these bytes read back as last written.
- R3: Words are big-endian: the byte at the even (lower) address holds bits 15:8.
- R4: A high flag is set only when the reading is strictly greater than its high limit; equality leaves it clear.
- R5: A low flag is set only when the reading is strictly less than its low limit; equality leaves it clear.
- R6: Temperature readings and limits compare as two's-complement signed 16-bit values. The other four quantities compare as unsigned.
- R7: Alarm byte 112 holds, from bit 7 to bit 0: temperature high, temperature low, supply high, supply low, bias high, bias low, transmit high, transmit low. Byte 113 bit 7 is receive high, bit 6 is receive low, and bits 5..0 read 0.
- R8: Warning bytes 116 and 117 use the R7 bit layout, driven by the warning limits.
- R9: Flags load only on a cycle with the sample strobe high, and all four bytes change together. They use the stored words as they stood before any write in that same cycle. Writes without a strobe leave the flags unchanged.
- R10: Writes to addresses outside the limit and reading regions, including the flag bytes, change nothing. Reads of addresses that map to nothing return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 8 | Byte write address |
| wr_data | input | 8 | Byte write data |
| sample | input | 1 | Evaluate strobe; loads all flags |
| rd_addr | input | 8 | Byte read address |
| rd_data | output | 8 | Combinational read data |

## Verification
The bench builds the block with its defaults: five quantities, 16-bit words, and only quantity 0 marked signed. With these values the signed and unsigned compare variants run side by side, so one reading pattern can flip a flag on one path and not on the other. Ten of the sixteen flag bits are live, which leaves six reserved bits in the second byte of each pair to watch. The 2-byte words expose byte order and the lower-address-is-MSB rule. Random readings are drawn near their limits often enough to hit the strict-compare edges.

// File: rtl/diag_cmp_pkg.sv
package diag_cmp_pkg;
   // order of the four limit words inside one quantity group
   typedef enum logic [1:0] {
      LIM_HI_ALM = 2'd0,
      LIM_LO_ALM = 2'd1,
      LIM_HI_WRN = 2'd2,
      LIM_LO_WRN = 2'd3
   } limit_e;

   localparam int LIMITS_PER_QTY = 4;

   // bit index of a flag inside a flag vector packed from its MSB down
   function automatic int flag_pos(input int q, input bit is_low, input int total);
      return total - 1 - 2 * q - (is_low ? 1 : 0);
   endfunction
endpackage

// File: rtl/diag_word_reg.sv
module diag_word_reg #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 8,
   parameter int BASE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] word,
   output logic              rd_hit,
   output logic [7:0]        rd_byte
);
   localparam int BPW = WORD_W / 8;

   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (wr_en) begin
         for (int b = 0; b < BPW; b++) begin
            if (wr_addr == ADDR_W'(BASE + b))
               word_q[WORD_W-1-8*b -: 8] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_hit  = 1'b0;
      rd_byte = 8'h00;
      for (int b = 0; b < BPW; b++) begin
         if (rd_addr == ADDR_W'(BASE + b)) begin
            rd_hit  = 1'b1;
            rd_byte = word_q[WORD_W-1-8*b -: 8];
         end
      end
   end

   assign word = word_q;
endmodule

// File: rtl/diag_word_store.sv
module diag_word_store #(
   parameter int WORD_W   = 16,
   parameter int ADDR_W   = 8,
   parameter int NUM_QTY  = 5,
   parameter int THR_BASE = 0,
   parameter int VAL_BASE = 96
) (
   input  logic                                                      clk,
   input  logic                                                      rst_n,
   input  logic                                                      wr_en,
   input  logic [ADDR_W-1:0]                                         wr_addr,
   input  logic [7:0]                                                wr_data,
   input  logic [ADDR_W-1:0]                                         rd_addr,
   output logic [NUM_QTY*diag_cmp_pkg::LIMITS_PER_QTY-1:0][WORD_W-1:0] thr_words,
   output logic [NUM_QTY-1:0][WORD_W-1:0]                             val_words,
   output logic [7:0]                                                rd_byte
);
   localparam int BPW     = WORD_W / 8;
   localparam int NUM_THR = NUM_QTY * diag_cmp_pkg::LIMITS_PER_QTY;
   localparam int NUM_ALL = NUM_THR + NUM_QTY;

   logic [NUM_ALL-1:0][WORD_W-1:0] all_words;
   logic [NUM_ALL-1:0]             hit_v;
   logic [NUM_ALL-1:0][7:0]        byte_v;

   for (genvar i = 0; i < NUM_ALL; i++) begin : g_word
      localparam int W_BASE = (i < NUM_THR) ? (THR_BASE + i * BPW)
                                            : (VAL_BASE + (i - NUM_THR) * BPW);
      diag_word_reg #(
         .WORD_W (WORD_W),
         .ADDR_W (ADDR_W),
         .BASE   (W_BASE)
      ) i_word (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_addr (wr_addr),
         .wr_data (wr_data),
         .rd_addr (rd_addr),
         .word    (all_words[i]),
         .rd_hit  (hit_v[i]),
         .rd_byte (byte_v[i])
      );
   end

   always_comb begin
      rd_byte = 8'h00;
      for (int i = 0; i < NUM_ALL; i++) begin
         if (hit_v[i]) rd_byte = rd_byte | byte_v[i];
      end
   end

   assign thr_words = all_words[NUM_THR-1:0];
   assign val_words = all_words[NUM_ALL-1:NUM_THR];
endmodule

// File: rtl/diag_limit_cmp.sv
module diag_limit_cmp #(
   parameter int WORD_W    = 16,
   parameter bit IS_SIGNED = 1'b0
) (
   input  logic [WORD_W-1:0] value,
   input  logic [WORD_W-1:0] hi_lim,
   input  logic [WORD_W-1:0] lo_lim,
   output logic              above,
   output logic              below
);
   if (IS_SIGNED) begin : g_signed
      assign above = $signed(value) > $signed(hi_lim);
      assign below = $signed(value) < $signed(lo_lim);
   end else begin : g_unsigned
      assign above = value > hi_lim;
      assign below = value < lo_lim;
   end
endmodule

// File: rtl/diag_flag_pack.sv
module diag_flag_pack #(
   parameter int NUM_QTY = 5,
   parameter int FLAG_W  = 16
) (
   input  logic [NUM_QTY-1:0] above,
   input  logic [NUM_QTY-1:0] below,
   output logic [FLAG_W-1:0]  flags
);
   always_comb begin
      flags = '0;
      for (int q = 0; q < NUM_QTY; q++) begin
         flags[diag_cmp_pkg::flag_pos(q, 1'b0, FLAG_W)] = above[q];
         flags[diag_cmp_pkg::flag_pos(q, 1'b1, FLAG_W)] = below[q];
      end
   end
endmodule

// File: rtl/diag_threshold_monitor.sv
module diag_threshold_monitor #(
   parameter int                 NUM_QTY     = 5,
   parameter int                 WORD_W      = 16,
   parameter int                 ADDR_W      = 8,
   parameter int                 THR_BASE    = 0,
   parameter int                 VAL_BASE    = 96,
   parameter int                 ALARM_BASE  = 112,
   parameter int                 WARN_BASE   = 116,
   parameter logic [NUM_QTY-1:0] SIGNED_MASK = NUM_QTY'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              sample,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   import diag_cmp_pkg::*;

   localparam int BPW        = WORD_W / 8;
   localparam int NUM_THR    = NUM_QTY * LIMITS_PER_QTY;
   localparam int FLAG_BYTES = (2 * NUM_QTY + 7) / 8;
   localparam int FLAG_W     = FLAG_BYTES * 8;

   // elaboration-time parameter checks
   if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
      $error("WORD_W must be a positive multiple of 8");
   end
   if (THR_BASE + NUM_THR * BPW > VAL_BASE) begin : g_bad_thr
      $error("limit region overlaps reading region");
   end
   if (VAL_BASE + NUM_QTY * BPW > ALARM_BASE) begin : g_bad_val
      $error("reading region overlaps alarm bytes");
   end
   if (ALARM_BASE + FLAG_BYTES > WARN_BASE) begin : g_bad_alm
      $error("alarm bytes overlap warning bytes");
   end
   if (WARN_BASE + FLAG_BYTES > (1 << ADDR_W)) begin : g_bad_wrn
      $error("warning bytes exceed address space");
   end

   logic [NUM_THR-1:0][WORD_W-1:0] thr_words;
   logic [NUM_QTY-1:0][WORD_W-1:0] val_words;
   logic [7:0]                     store_byte;

   diag_word_store #(
      .WORD_W   (WORD_W),
      .ADDR_W   (ADDR_W),
      .NUM_QTY  (NUM_QTY),
      .THR_BASE (THR_BASE),
      .VAL_BASE (VAL_BASE)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .thr_words (thr_words),
      .val_words (val_words),
      .rd_byte   (store_byte)
   );

   logic [NUM_QTY-1:0] alm_above, alm_below, wrn_above, wrn_below;

   for (genvar q = 0; q < NUM_QTY; q++) begin : g_qty
      diag_limit_cmp #(
         .WORD_W    (WORD_W),
         .IS_SIGNED (SIGNED_MASK[q])
      ) i_alm_cmp (
         .value  (val_words[q]),
         .hi_lim (thr_words[q*LIMITS_PER_QTY + int'(LIM_HI_ALM)]),
         .lo_lim (thr_words[q*LIMITS_PER_QTY + int'(LIM_LO_ALM)]),
         .above  (alm_above[q]),
         .below  (alm_below[q])
      );
      diag_limit_cmp #(
         .WORD_W    (WORD_W),
         .IS_SIGNED (SIGNED_MASK[q])
      ) i_wrn_cmp (
         .value  (val_words[q]),
         .hi_lim (thr_words[q*LIMITS_PER_QTY + int'(LIM_HI_WRN)]),
         .lo_lim (thr_words[q*LIMITS_PER_QTY + int'(LIM_LO_WRN)]),
         .above  (wrn_above[q]),
         .below  (wrn_below[q])
      );
   end

   logic [FLAG_W-1:0] alarm_next, warn_next;
   logic [FLAG_W-1:0] alarm_q, warn_q;

   diag_flag_pack #(.NUM_QTY(NUM_QTY), .FLAG_W(FLAG_W)) i_alm_pack (
      .above (alm_above),
      .below (alm_below),
      .flags (alarm_next)
   );
   diag_flag_pack #(.NUM_QTY(NUM_QTY), .FLAG_W(FLAG_W)) i_wrn_pack (
      .above (wrn_above),
      .below (wrn_below),
      .flags (warn_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q <= '0;
         warn_q  <= '0;
      end else if (sample) begin
         alarm_q <= alarm_next;
         warn_q  <= warn_next;
      end
   end

   always_comb begin
      rd_data = store_byte;
      for (int fb = 0; fb < FLAG_BYTES; fb++) begin
         if (rd_addr == ADDR_W'(ALARM_BASE + fb)) rd_data = alarm_q[FLAG_W-1-8*fb -: 8];
         if (rd_addr == ADDR_W'(WARN_BASE + fb))  rd_data = warn_q[FLAG_W-1-8*fb -: 8];
      end
   end
endmodule

// File: rtl/diag_threshold_monitor_chk.sv
module diag_threshold_monitor_chk #(
   parameter int NUM_QTY    = 5,
   parameter int WORD_W     = 16,
   parameter int ADDR_W     = 8,
   parameter int THR_BASE   = 0,
   parameter int VAL_BASE   = 96,
   parameter int ALARM_BASE = 112,
   parameter int FLAG_W     = 16
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 sample,
   input logic                                 wr_en,
   input logic [ADDR_W-1:0]                    wr_addr,
   input logic [ADDR_W-1:0]                    rd_addr,
   input logic [7:0]                           rd_data,
   input logic [FLAG_W-1:0]                    alarm_next,
   input logic [FLAG_W-1:0]                    warn_next,
   input logic [FLAG_W-1:0]                    alarm_q,
   input logic [FLAG_W-1:0]                    warn_q,
   input logic [NUM_QTY*4-1:0][WORD_W-1:0]     thr_words,
   input logic [NUM_QTY-1:0][WORD_W-1:0]       val_words
);
   localparam int BPW = WORD_W / 8;
   localparam logic [FLAG_W-1:0] RSV_MASK = FLAG_W'((1 << (FLAG_W - 2 * NUM_QTY)) - 1);

   logic mapped_wr;
   always_comb begin
      mapped_wr = ((int'(wr_addr) >= THR_BASE) && (int'(wr_addr) < THR_BASE + NUM_QTY * 4 * BPW)) ||
                  ((int'(wr_addr) >= VAL_BASE) && (int'(wr_addr) < VAL_BASE + NUM_QTY * BPW));
   end

   p_flags_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sample |=> (alarm_q == $past(alarm_next)) && (warn_q == $past(warn_next)));

   p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sample |=> $stable(alarm_q) && $stable(warn_q));

   p_alarm_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_q & RSV_MASK) == '0);

   p_warn_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (warn_q & RSV_MASK) == '0);

   p_alarm_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(ALARM_BASE)) |-> (rd_data == alarm_q[FLAG_W-1 -: 8]));

   p_stray_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mapped_wr) |=> $stable(thr_words) && $stable(val_words));
endmodule

bind diag_threshold_monitor diag_threshold_monitor_chk #(
   .NUM_QTY    (NUM_QTY),
   .WORD_W     (WORD_W),
   .ADDR_W     (ADDR_W),
   .THR_BASE   (THR_BASE),
   .VAL_BASE   (VAL_BASE),
   .ALARM_BASE (ALARM_BASE),
   .FLAG_W     (FLAG_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample     (sample),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .alarm_next (alarm_next),
   .warn_next  (warn_next),
   .alarm_q    (alarm_q),
   .warn_q     (warn_q),
   .thr_words  (thr_words),
   .val_words  (val_words)
);

// File: tb/test_diag_threshold_monitor.sv
module test_diag_threshold_monitor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       sample = 1'b0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [15:0] thr_m [20];
   logic [15:0] val_m [5];
   logic [15:0] alm_m, wrn_m;

   always #2 clk = ~clk;

   diag_threshold_monitor i_diag_threshold_monitor (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sample  (sample),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   function automatic logic [15:0] calc_flags(input bit warn);
      logic [15:0] f = '0;
      for (int q = 0; q < 5; q++) begin
         logic [15:0] hi = thr_m[q*4 + (warn ? 2 : 0)];
         logic [15:0] lo = thr_m[q*4 + (warn ? 3 : 1)];
         logic [15:0] v  = val_m[q];
         bit a, b;
         if (q == 0) begin
            a = $signed(v) > $signed(hi);
            b = $signed(v) < $signed(lo);
         end else begin
            a = v > hi;
            b = v < lo;
         end
         f[15-2*q] = a;
         f[14-2*q] = b;
      end
      return f;
   endfunction

   task automatic mdl_byte(input logic [7:0] a, input logic [7:0] d);
      if (a < 8'd40) begin
         if (a[0]) thr_m[a/2][7:0] = d; else thr_m[a/2][15:8] = d;
      end else if (a >= 8'd96 && a < 8'd106) begin
         if (a[0]) val_m[(a-96)/2][7:0] = d; else val_m[(a-96)/2][15:8] = d;
      end
   endtask

   task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
      mdl_byte(a, d);
   endtask

   task automatic set_thr(input int q, input int l, input logic [15:0] w);
      wr_byte(8'(q*8 + l*2), w[15:8]);
      wr_byte(8'(q*8 + l*2 + 1), w[7:0]);
   endtask

   task automatic set_val(input int q, input logic [15:0] w);
      wr_byte(8'(96 + q*2), w[15:8]);
      wr_byte(8'(96 + q*2 + 1), w[7:0]);
   endtask

   task automatic strobe();
      @(negedge clk);
      sample = 1'b1;
      alm_m = calc_flags(1'b0);
      wrn_m = calc_flags(1'b1);
      @(posedge clk);
      #1 sample = 1'b0;
   endtask

   task automatic strobe_with_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sample = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
      alm_m = calc_flags(1'b0);
      wrn_m = calc_flags(1'b1);
      @(posedge clk);
      #1 sample = 1'b0; wr_en = 1'b0;
      mdl_byte(a, d);
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      rd_addr = a;
      #1;
      n_vec++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s addr %0d: got %02h expected %02h", tag, a, rd_data, exp);
      end
   endtask

   task automatic check_flags(input string tag);
      rd_chk(8'd112, alm_m[15:8], {tag, " R7 alarm hi byte"});
      rd_chk(8'd113, alm_m[7:0],  {tag, " R7 alarm lo byte"});
      rd_chk(8'd116, wrn_m[15:8], {tag, " R8 warn hi byte"});
      rd_chk(8'd117, wrn_m[7:0],  {tag, " R8 warn lo byte"});
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      foreach (thr_m[i]) thr_m[i] = '0;
      foreach (val_m[i]) val_m[i] = '0;
      alm_m = '0; wrn_m = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd_chk(8'd0,   8'h00, "R1 limit byte");
      rd_chk(8'd39,  8'h00, "R1 limit byte");
      rd_chk(8'd96,  8'h00, "R1 reading byte");
      rd_chk(8'd105, 8'h00, "R1 reading byte");
      check_flags("R1");

      // R2 / R3: placement and byte order
      set_thr(1, 2, 16'hA55A);
      rd_chk(8'd12, 8'hA5, "R2 R3 supply hi warn msb");
      rd_chk(8'd13, 8'h5A, "R2 R3 supply hi warn lsb");
      set_val(3, 16'h1234);
      rd_chk(8'd102, 8'h12, "R2 R3 tx reading msb");
      rd_chk(8'd103, 8'h34, "R2 R3 tx reading lsb");

      // R4 / R5: strict comparison at the limits, all quantities
      for (int q = 0; q < 5; q++) begin
         set_thr(q, 0, 16'd1000); set_thr(q, 1, 16'd500);
         set_thr(q, 2, 16'd900);  set_thr(q, 3, 16'd600);
      end
      for (int q = 0; q < 5; q++) set_val(q, 16'd1000);
      strobe(); check_flags("R4 equal hi");
      for (int q = 0; q < 5; q++) set_val(q, 16'd1001);
      strobe(); check_flags("R4 above hi");
      for (int q = 0; q < 5; q++) set_val(q, 16'd500);
      strobe(); check_flags("R5 equal lo");
      for (int q = 0; q < 5; q++) set_val(q, 16'd499);
      strobe(); check_flags("R5 below lo");
      rd_chk(8'd112, 8'h55, "R7 all low alarms");
      rd_chk(8'd113, 8'h40, "R7 rx low alarm");

      // R6: signed temperature, unsigned supply
      set_thr(0, 0, 16'h0050); set_thr(0, 1, 16'hFFD8);
      set_val(0, 16'hFFD0);
      set_thr(1, 0, 16'h8000);
      set_val(1, 16'h9000);
      strobe(); check_flags("R6 signedness");
      rd_chk(8'd112, {2'b01, 2'b10, alm_m[11:8]}, "R6 temp low, supply high");

      // R9: writes without strobe leave flags alone
      set_val(2, 16'hFFFF);
      set_val(4, 16'h0000);
      check_flags("R9 hold");
      // R9: strobe samples pre-write contents
      strobe_with_write(8'd100, 8'h00);
      check_flags("R9 same-cycle write");
      strobe(); check_flags("R9 next strobe");

      // R10: stray writes
      wr_byte(8'd40, 8'hFF);
      wr_byte(8'd95, 8'hFF);
      wr_byte(8'd112, 8'hFF);
      wr_byte(8'd117, 8'hFF);
      wr_byte(8'd200, 8'hFF);
      rd_chk(8'd40,  8'h00, "R10 gap read");
      rd_chk(8'd95,  8'h00, "R10 gap read");
      rd_chk(8'd200, 8'h00, "R10 high read");
      check_flags("R10 flag write ignored");
      rd_chk(8'd12, thr_m[6][15:8], "R10 mapped intact");
      strobe(); check_flags("R10 after stray");

      // random sweep with near-limit values
      for (int it = 0; it < 150; it++) begin
         for (int k = 0; k < 20; k++) set_thr(k/4, k%4, 16'($urandom));
         for (int q = 0; q < 5; q++) begin
            int sel = $urandom % 4;
            logic [15:0] base = thr_m[q*4 + ($urandom % 4)];
            case (sel)
               0: set_val(q, base);
               1: set_val(q, base + 16'd1);
               2: set_val(q, base - 16'd1);
               default: set_val(q, 16'($urandom));
            endcase
         end
         strobe();
         check_flags("R4 R5 R6 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule